// File: doc/BRIEF.md
# Indirect and Windowed Buffer RAM Port

This block holds a 768-byte single-port buffer RAM and gives a processor two ways to reach it. The first way is indirect. Software loads a 10-bit index into a pair of special-function registers, a low byte and a high byte. It then writes or reads a data register to move one byte at that index. The second way is direct. The same bytes appear as a memory window at addresses 0x0400 to 0x06FF. One select input decides whether the window sits in code (fetch) space or in external data space.

Accesses that fall outside the window, or that target the space the select input does not pick, are not served here. The block flags them on a per-space external-route output and never stalls them. The RAM reads synchronously, so every byte read out of it appears one cycle after the access. Indirect data-register accesses win over direct window accesses in the same cycle. The losing direct access is held off through its ready output.

Top module: `buf_ram_port`

## Requirements
- R1: After reset, the low index register (SFR 0xA1) and the high index register (SFR 0xA2) both read 0x00.
- R2: An SFR write to 0xA1 sets index bits 7:0. A write to 0xA2 sets index bits 9:8 from its data bits 1:0 and drops data bits 7:2, so a read of 0xA2 returns 0 in bits 7:2. Any SFR read returns its data on `sfr_rdata` in the cycle after `sfr_rd` is sampled.
- R3: An SFR write to the data register 0x9F stores the byte at the current index at that clock edge, with no extra write cycle.
- R4: An SFR read of 0x9F returns, one cycle later, the byte held in RAM at the current index, including bytes that direct window writes placed there.
- R5: When the index is 768 or more, a data-register write leaves every RAM byte unchanged, and a data-register read returns 0x00.
- R6: With `map_code`=1, a code request to address A in 0x0400..0x06FF is accepted when `code_ready` is 1, `code_ext` stays 0, and `code_rdata` shows RAM byte A-0x0400 in the next cycle.
- R7: With `map_code`=0, a data request in 0x0400..0x06FF reads or writes RAM byte A-0x0400 (`xd_we`=1 writes `xd_wdata`; a read shows on `xd_rdata` next cycle), and `xd_ext` stays 0.
- R8: A request outside the window, or in the space not picked by `map_code`, raises that space's `*_ext` output in the same cycle, keeps its ready at 1, and leaves RAM contents unchanged.
- R9: In a cycle with an SFR read or write of 0x9F, a window request sees ready 0 and has no effect. It completes in the first cycle without such an SFR access.
- R10: SFR accesses to any address other than 0x9F, 0xA1 and 0xA2 change nothing and read back 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, one cycle after the read |
| map_code | input | 1 | Window placement: 1 = code space, 0 = external data space |
| code_req | input | 1 | Code fetch request |
| code_addr | input | 16 | Code fetch address |
| code_ready | output | 1 | Code request accepted this cycle |
| code_ext | output | 1 | Code request goes to external memory |
| code_rdata | output | 8 | Window fetch data, one cycle after acceptance |
| xd_req | input | 1 | External data request |
| xd_we | input | 1 | External data write enable |
| xd_addr | input | 16 | External data address |
| xd_wdata | input | 8 | External data write byte |
| xd_ready | output | 1 | Data request accepted this cycle |
| xd_ext | output | 1 | Data request goes to external memory |
| xd_rdata | output | 8 | Window read data, one cycle after acceptance |

## Verification
The assertions assume the processor never raises `sfr_rd` and `sfr_wr` in the same cycle. They also assume a direct requester holds its request and address steady while ready is low. The bench drives every SFR access as a single-strobe cycle on the falling edge. It repeats a stalled window request unchanged until ready returns. It compares results only in the cycle the requirements name, after the index and window contents were set by earlier accesses.

// File: rtl/buf_ram_port.sv
module buf_ram_port #(
  parameter int          DEPTH    = 768,
  parameter int          IDX_W    = 10,
  parameter int          AW       = 16,
  parameter logic [15:0] WIN_BASE = 16'h0400,
  parameter logic [7:0]  SFR_DATA = 8'h9F,
  parameter logic [7:0]  SFR_IDXL = 8'hA1,
  parameter logic [7:0]  SFR_IDXH = 8'hA2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sfr_addr,
  input  logic          sfr_wr,
  input  logic          sfr_rd,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          map_code,
  input  logic          code_req,
  input  logic [AW-1:0] code_addr,
  output logic          code_ready,
  output logic          code_ext,
  output logic [7:0]    code_rdata,
  input  logic          xd_req,
  input  logic          xd_we,
  input  logic [AW-1:0] xd_addr,
  input  logic [7:0]    xd_wdata,
  output logic          xd_ready,
  output logic          xd_ext,
  output logic [7:0]    xd_rdata
);
  localparam int HI_W = IDX_W - 8;
  localparam logic [AW-1:0] WIN_END = AW'(WIN_BASE) + AW'(DEPTH);

  logic [7:0]      idx_lo;
  logic [HI_W-1:0] idx_hi;
  logic [IDX_W-1:0] idx;
  logic            idx_ok;
  logic [7:0]      mem [DEPTH];
  logic [7:0]      q;
  logic            rd_from_ram;
  logic [7:0]      rd_hold;

  assign idx    = {idx_hi, idx_lo};
  assign idx_ok = 32'(idx) < DEPTH;

  logic dp_acc, code_in, xd_in, g_sfr, g_code, g_xd;
  logic [AW-1:0] code_off, xd_off;

  assign dp_acc  = (sfr_wr | sfr_rd) && sfr_addr == SFR_DATA;
  assign code_in = code_addr >= AW'(WIN_BASE) && code_addr < WIN_END;
  assign xd_in   = xd_addr >= AW'(WIN_BASE) && xd_addr < WIN_END;
  assign code_off = code_addr - AW'(WIN_BASE);
  assign xd_off   = xd_addr - AW'(WIN_BASE);

  assign g_sfr  = dp_acc && idx_ok;
  assign g_code = code_req && map_code && code_in && !dp_acc;
  assign g_xd   = xd_req && !map_code && xd_in && !dp_acc;

  assign code_ext   = code_req && !(map_code && code_in);
  assign xd_ext     = xd_req && !(!map_code && xd_in);
  assign code_ready = !(code_req && map_code && code_in && dp_acc);
  assign xd_ready   = !(xd_req && !map_code && xd_in && dp_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_lo      <= '0;
      idx_hi      <= '0;
      rd_from_ram <= 1'b0;
      rd_hold     <= '0;
    end else begin
      if (sfr_wr && sfr_addr == SFR_IDXL) idx_lo <= sfr_wdata;
      if (sfr_wr && sfr_addr == SFR_IDXH) idx_hi <= sfr_wdata[HI_W-1:0];
      if (sfr_rd) begin
        rd_from_ram <= g_sfr;
        case (sfr_addr)
          SFR_IDXL: rd_hold <= idx_lo;
          SFR_IDXH: rd_hold <= 8'(idx_hi);
          default:  rd_hold <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (g_sfr) begin
      if (sfr_wr) mem[idx] <= sfr_wdata;
      else        q <= mem[idx];
    end else if (g_code) begin
      q <= mem[code_off[IDX_W-1:0]];
    end else if (g_xd) begin
      if (xd_we) mem[xd_off[IDX_W-1:0]] <= xd_wdata;
      else       q <= mem[xd_off[IDX_W-1:0]];
    end
  end

  assign sfr_rdata  = rd_from_ram ? q : rd_hold;
  assign code_rdata = q;
  assign xd_rdata   = q;

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_sfr, g_code, g_xd}));

  p_oob_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && sfr_addr == SFR_DATA && !idx_ok) |=> sfr_rdata == 8'h00);

  p_hi_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && sfr_addr == SFR_IDXH) |=> sfr_rdata[7:HI_W] == '0);

  p_miss_never_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_ext |-> code_ready) and (xd_ext |-> xd_ready));

  p_dp_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == SFR_DATA && idx_ok) |=> mem[$past(idx)] == $past(sfr_wdata));

  p_other_sfr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && sfr_addr != SFR_DATA && sfr_addr != SFR_IDXL && sfr_addr != SFR_IDXH)
      |=> sfr_rdata == 8'h00);
endmodule

// File: tb/buf_ram_port_bench.sv
module buf_ram_port_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0;
  logic sfr_wr = 0, sfr_rd = 0;
  logic [7:0] sfr_rdata;
  logic map_code = 0;
  logic code_req = 0;
  logic [15:0] code_addr = 0;
  logic code_ready, code_ext;
  logic [7:0] code_rdata;
  logic xd_req = 0, xd_we = 0;
  logic [15:0] xd_addr = 0;
  logic [7:0] xd_wdata = 0;
  logic xd_ready, xd_ext;
  logic [7:0] xd_rdata;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  buf_ram_port u_buf_ram_port (
    .clk(clk), .rst_n(rst_n),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .map_code(map_code),
    .code_req(code_req), .code_addr(code_addr), .code_ready(code_ready),
    .code_ext(code_ext), .code_rdata(code_rdata),
    .xd_req(xd_req), .xd_we(xd_we), .xd_addr(xd_addr), .xd_wdata(xd_wdata),
    .xd_ready(xd_ready), .xd_ext(xd_ext), .xd_rdata(xd_rdata)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sfr_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic sfr_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_rd = 1;
    @(negedge clk); d = sfr_rdata; sfr_rd = 0;
  endtask

  task automatic xd_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); xd_addr = a; xd_wdata = d; xd_we = 1; xd_req = 1;
    @(negedge clk); xd_req = 0; xd_we = 0;
  endtask

  task automatic xd_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); xd_addr = a; xd_we = 0; xd_req = 1;
    @(negedge clk); xd_req = 0; d = xd_rdata;
  endtask

  task automatic code_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); code_addr = a; code_req = 1;
    @(negedge clk); code_req = 0; d = code_rdata;
  endtask

  // {map, op, addr, data}; op 0 sfr write, 1 sfr read, 2 xd write, 3 xd read, 4 code read
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'h00A1, 8'h10},
    {1'b1, 3'd0, 16'h00A2, 8'h01},
    {1'b1, 3'd0, 16'h009F, 8'h5A},   // R3
    {1'b1, 3'd1, 16'h009F, 8'h5A},   // R4
    {1'b1, 3'd4, 16'h0510, 8'h5A},   // R6
    {1'b0, 3'd2, 16'h0400, 8'hC3},   // R7
    {1'b0, 3'd0, 16'h00A1, 8'h00},
    {1'b0, 3'd0, 16'h00A2, 8'h00},
    {1'b0, 3'd1, 16'h009F, 8'hC3},   // R4 R7
    {1'b0, 3'd2, 16'h06FF, 8'h99},   // R7 top byte
    {1'b0, 3'd3, 16'h06FF, 8'h99},   // R7
    {1'b0, 3'd0, 16'h00A2, 8'hFE},   // R2
    {1'b0, 3'd1, 16'h00A2, 8'h02},   // R2 upper bits dropped
    {1'b0, 3'd0, 16'h00A1, 8'hFF},
    {1'b0, 3'd1, 16'h009F, 8'h99},   // R4 index 0x2FF
    {1'b0, 3'd1, 16'h0055, 8'h00}    // R10
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    sfr_read(8'hA1, d); check("R1 idx_lo", d, 8'h00);
    sfr_read(8'hA2, d); check("R1 idx_hi", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [15:0] a;
      logic [7:0] v;
      map_code = VEC[i][27];
      op = VEC[i][26:24];
      a = VEC[i][23:8];
      v = VEC[i][7:0];
      case (op)
        3'd0: sfr_write(a[7:0], v);
        3'd1: begin sfr_read(a[7:0], d); check($sformatf("R4/R2/R10 vec%0d", i), d, v); end
        3'd2: xd_write(a, v);
        3'd3: begin xd_read(a, d); check($sformatf("R7 vec%0d", i), d, v); end
        default: begin code_read(a, d); check($sformatf("R6 vec%0d", i), d, v); end
      endcase
    end

    // R10: write to unused SFR leaves index registers untouched
    sfr_write(8'hA0, 8'h33);
    sfr_read(8'hA1, d); check("R10 idx_lo kept", d, 8'hFF);

    // R5: out-of-range index
    map_code = 0;
    xd_write(16'h0400, 8'h11);
    sfr_write(8'hA1, 8'h00);
    sfr_write(8'hA2, 8'h03);
    sfr_write(8'h9F, 8'h77);
    sfr_read(8'h9F, d); check("R5 oob read", d, 8'h00);
    xd_read(16'h0400, d); check("R5 oob write ignored", d, 8'h11);

    // R8: window in code space, data request goes external
    map_code = 1;
    sfr_write(8'hA2, 8'h00);
    sfr_write(8'hA1, 8'h50);
    sfr_write(8'h9F, 8'h42);
    @(negedge clk); xd_addr = 16'h0450; xd_wdata = 8'hEE; xd_we = 1; xd_req = 1;
    #1 check("R8 xd_ext", {15'd0, xd_ext}, 16'd1);
    check("R8 xd_ready", {15'd0, xd_ready}, 16'd1);
    @(negedge clk); xd_req = 0; xd_we = 0;
    code_read(16'h0450, d); check("R8 ram untouched", d, 8'h42);
    @(negedge clk); code_addr = 16'h0300; code_req = 1;
    #1 check("R8 code below window", {15'd0, code_ext}, 16'd1);
    @(negedge clk); code_req = 0;
    @(negedge clk); code_addr = 16'h0450; code_req = 1;
    #1 check("R6 code_ext low in window", {15'd0, code_ext}, 16'd0);
    @(negedge clk); code_req = 0;

    // R9: conflict between data register write and window write
    map_code = 0;
    sfr_write(8'hA1, 8'h20);
    @(negedge clk);
    sfr_addr = 8'h9F; sfr_wdata = 8'hAB; sfr_wr = 1;
    xd_addr = 16'h0421; xd_wdata = 8'hCD; xd_we = 1; xd_req = 1;
    #1 check("R9 stall", {15'd0, xd_ready}, 16'd0);
    @(negedge clk); sfr_wr = 0;
    #1 check("R9 resume", {15'd0, xd_ready}, 16'd1);
    @(negedge clk); xd_req = 0; xd_we = 0;
    sfr_read(8'h9F, d); check("R9 sfr write kept", d, 8'hAB);
    xd_read(16'h0421, d); check("R9 window write done", d, 8'hCD);

    // R3: data register write visible right after through window
    sfr_write(8'hA1, 8'h05);
    sfr_write(8'h9F, 8'h6C);
    xd_read(16'h0405, d); check("R3 immediate write", d, 8'h6C);

    // R4: direct write then indirect read shows it
    xd_write(16'h0405, 8'h3E);
    sfr_read(8'h9F, d); check("R4 reflects window write", d, 8'h3E);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule